// File: doc/BRIEF.md
# Signed Serial Shift-Add Multiplier

This block multiplies two N-bit two's-complement operands and returns their 2N-bit two's-complement product. It is serial. One multiplier bit is consumed per clock, starting from the least significant bit. A running 2N-bit sum begins at zero. In each step the sum receives one of three terms: the sign-extended multiplicand shifted into position, zero, or, in the step for the multiplier's sign bit, the negated shifted multiplicand. The negation is the bitwise inverse plus one. Carries out of the 2N-bit sum are dropped. Neither operand is converted to magnitude form, and no recoding of the multiplier is used.

A client raises `start` with `a` and `b` while `busy` is low. The block captures the operands and raises `busy`. After N steps it pulses `done` for one cycle. The product is then read from `product`, which keeps its value until the next accepted start.

Top module: `smul_serial`

## Requirements
- R1: Synchronous active-high `rst` clears `busy`, `done` and `product` to zero at the next rising edge, including in the middle of a computation.
- R2: A `start` sampled high while `busy` is low captures `a` and `b`, and `busy` reads 1 in the following cycle.
- R3: `done` is high for exactly one cycle. That cycle follows the N-th rising edge after the edge that accepted the start. `busy` is low in the `done` cycle, and `done` is low in the N-1 cycles before it.
- R4: In the `done` cycle, `product` equals the signed product of the captured `a` and `b`, both taken as two's complement, written as a 2N-bit two's-complement value. This holds for every operand pair.
- R5: When the multiplier sign bit (bit N-1 of `b`) is 1, the final step subtracts the shifted multiplicand. For N=4, `a`=4'b1010 with `b`=4'b1011 gives 8'b00011110, and `a`=4'b1010 with `b`=4'b0101 gives 8'b11100010.
- R6: The most negative operands, -2^(N-1) times -2^(N-1), give +2^(2N-2). For N=4, 4'b1000 times 4'b1000 gives 8'h40.
- R7: A `start` raised while `busy` is high is ignored. The running computation keeps its operands, its `done` timing and its product.
- R8: From the `done` cycle until the next accepted start, `product` keeps its value and `done` stays low, whatever the values on `a` and `b`.
- R9: A negative multiplicand is sign-extended into the upper half. For N=4, 4'b1111 times 4'b0011 gives 8'hFD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a multiplication; taken only while idle |
| a | input | N | Multiplicand, two's complement |
| b | input | N | Multiplier, two's complement |
| busy | output | 1 | High while a multiplication is in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2N | Signed product, held until the next accepted start |

## Verification
`busy` is due one cycle after the edge that accepts a start. `done` and the product are due after exactly N further edges, and the held product is checked one cycle after that. The bench drives inputs and samples outputs on the falling clock edge. It counts rising edges from the accepting edge, so it checks that `done` is low in each of the N-1 cycles before the pulse, and then checks the pulse, `busy` and `product` in that exact cycle. Every operand pair for N=4 is run this way, against a product worked out in the bench from the signed operand values. The ignored-start case and the mid-run reset are also checked at fixed cycle offsets.

// File: rtl/smul_pkg.sv
package smul_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } smul_state_e;

    typedef enum logic [1:0] {
        TERM_ZERO  = 2'd0,
        TERM_PLUS  = 2'd1,
        TERM_MINUS = 2'd2
    } smul_term_e;

    function automatic smul_term_e term_for(input logic mbit, input logic final_step);
        if (!mbit)
            return TERM_ZERO;
        else if (final_step)
            return TERM_MINUS;
        else
            return TERM_PLUS;
    endfunction

endpackage

// File: rtl/smul_seq_ctrl.sv
module smul_seq_ctrl
    import smul_pkg::*;
#(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic load,
    output logic step_en,
    output logic final_step,
    output logic done
);
    localparam int SW = (N > 1) ? $clog2(N) : 1;
    localparam logic [SW-1:0] LAST_STEP = SW'(N - 1);

    smul_state_e     state_q;
    logic [SW-1:0]   step_q;

    assign busy       = (state_q == ST_RUN);
    assign load       = (state_q == ST_IDLE) && start;
    assign step_en    = busy;
    assign final_step = busy && (step_q == LAST_STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        step_q  <= '0;
                    end
                end
                ST_RUN: begin
                    if (final_step) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/smul_term_sel.sv
module smul_term_sel
    import smul_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [2*N-1:0] mcand,
    input  logic           mbit,
    input  logic           final_step,
    output logic [2*N-1:0] term
);
    localparam int PW = 2 * N;
    localparam logic [PW-1:0] ONE = PW'(1);

    smul_term_e kind;

    always_comb begin
        kind = term_for(mbit, final_step);
        unique case (kind)
            TERM_PLUS:  term = mcand;
            TERM_MINUS: term = ~mcand + ONE;
            default:    term = '0;
        endcase
    end
endmodule

// File: rtl/smul_accum.sv
module smul_accum #(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step_en,
    input  logic [N-1:0]   a_in,
    input  logic [N-1:0]   b_in,
    input  logic [2*N-1:0] term,
    output logic [2*N-1:0] mcand,
    output logic           mbit,
    output logic [2*N-1:0] acc
);
    localparam int PW = 2 * N;

    logic [N-1:0] mplier_q;

    assign mbit = mplier_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            mcand    <= '0;
            mplier_q <= '0;
        end else if (load) begin
            acc      <= '0;
            mcand    <= {{N{a_in[N-1]}}, a_in};
            mplier_q <= b_in;
        end else if (step_en) begin
            acc      <= acc + term;
            mcand    <= {mcand[PW-2:0], 1'b0};
            mplier_q <= {1'b0, mplier_q[N-1:1]};
        end
    end
endmodule

// File: rtl/smul_serial.sv
module smul_serial #(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic           busy,
    output logic           done,
    output logic [2*N-1:0] product
);
    localparam int PW = 2 * N;

    logic          load;
    logic          step_en;
    logic          final_step;
    logic          mbit;
    logic [PW-1:0] mcand;
    logic [PW-1:0] term;

    smul_seq_ctrl #(.N(N)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .busy       (busy),
        .load       (load),
        .step_en    (step_en),
        .final_step (final_step),
        .done       (done)
    );

    smul_term_sel #(.N(N)) u_term (
        .mcand      (mcand),
        .mbit       (mbit),
        .final_step (final_step),
        .term       (term)
    );

    smul_accum #(.N(N)) u_accum (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .step_en (step_en),
        .a_in    (a),
        .b_in    (b),
        .term    (term),
        .mcand   (mcand),
        .mbit    (mbit),
        .acc     (product)
    );
endmodule

// File: rtl/smul_serial_chk.sv
module smul_serial_chk #(
    parameter int N = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [N-1:0]   a,
    input logic [N-1:0]   b,
    input logic           busy,
    input logic           done,
    input logic [2*N-1:0] product
);
    localparam int PW = 2 * N;
    localparam int CW = $clog2(N + 1) + 1;

    logic [N-1:0]  a_cap;
    logic [N-1:0]  b_cap;
    logic [CW-1:0] cyc;
    logic [PW-1:0] expect_prod;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_cap <= '0;
            b_cap <= '0;
            cyc   <= '0;
        end else if (start && !busy) begin
            a_cap <= a;
            b_cap <= b;
            cyc   <= '0;
        end else if (busy) begin
            cyc <= cyc + 1'b1;
        end
    end

    always_comb begin
        expect_prod = PW'($signed({{N{a_cap[N-1]}}, a_cap}) * $signed({{N{b_cap[N-1]}}, b_cap}));
    end

    // R1: reset leaves the block idle with a cleared product
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!busy && !done && product == '0));

    // R2: an accepted start raises busy
    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R3: done lasts one cycle
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: done arrives N edges after the accepting edge, with busy low
    p_done_timing_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (cyc == CW'(N) && !busy));

    // R4: product is the signed product of the captured operands
    p_product_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (product == expect_prod));

    // R7: start while busy does not end the run early
    p_ignore_start_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && start && cyc < CW'(N - 1)) |=> busy);

    // R8: idle without start keeps the product
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));
endmodule

bind smul_serial smul_serial_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .a       (a),
    .b       (b),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/smul_serial_test.sv
module smul_serial_test;
    localparam int N = 4;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    // {a, b, expected product}: R5 pair, R5 pair, R6, R9, plain positive, zero
    localparam logic [15:0] VEC [0:5] = '{
        16'hAB1E, 16'hA5E2, 16'h8840, 16'hF3FD, 16'h7731, 16'h0800
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [N-1:0]   a = '0;
    logic [N-1:0]   b = '0;
    logic           busy;
    logic           done;
    logic [2*N-1:0] product;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    smul_serial #(.N(N)) uut (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .a       (a),
        .b       (b),
        .busy    (busy),
        .done    (done),
        .product (product)
    );

    task automatic expect_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [N-1:0] x, input logic [N-1:0] y,
                          input logic [2*N-1:0] exp, input string tag);
        logic [2*N-1:0] held;
        @(negedge clk);
        start = 1'b1; a = x; b = y;
        @(negedge clk);
        start = 1'b0;
        expect_eq("R2 busy after start", 64'(busy), 64'd1);
        for (int i = 1; i < N; i++) begin
            @(negedge clk);
            expect_eq("R3 done early", 64'(done), 64'd0);
        end
        @(negedge clk);
        expect_eq("R3 done pulse", 64'(done), 64'd1);
        expect_eq("R3 busy low at done", 64'(busy), 64'd0);
        expect_eq(tag, 64'(product), 64'(exp));
        held = product;
        a = ~x; b = ~y;
        @(negedge clk);
        expect_eq("R3 done one cycle", 64'(done), 64'd0);
        expect_eq("R8 product held", 64'(product), 64'(held));
    endtask

    function automatic logic [2*N-1:0] ref_mul(input logic [N-1:0] x, input logic [N-1:0] y);
        int sx;
        int sy;
        sx = x[N-1] ? int'(x) - (1 << N) : int'(x);
        sy = y[N-1] ? int'(y) - (1 << N) : int'(y);
        return (2*N)'(sx * sy);
    endfunction

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        expect_eq("R1 busy after reset", 64'(busy), 64'd0);
        expect_eq("R1 done after reset", 64'(done), 64'd0);
        expect_eq("R1 product after reset", 64'(product), 64'd0);

        // R4 R5 R6 R9 table vectors
        for (int k = 0; k < 6; k++) begin
            run_op(VEC[k][15:12], VEC[k][11:8], VEC[k][7:0], "R4 R5 R6 R9 table product");
        end

        // R4 exhaustive
        for (int x = 0; x < (1 << N); x++) begin
            for (int y = 0; y < (1 << N); y++) begin
                run_op(N'(x), N'(y), ref_mul(N'(x), N'(y)), "R4 exhaustive product");
            end
        end

        // R7 start while busy is ignored: 3 x 2 with a 7 x 7 request mid-run
        @(negedge clk);
        start = 1'b1; a = 4'd3; b = 4'd2;
        @(negedge clk);
        a = 4'd7; b = 4'd7;
        expect_eq("R7 busy", 64'(busy), 64'd1);
        @(negedge clk);
        start = 1'b0;
        expect_eq("R7 done not early", 64'(done), 64'd0);
        for (int i = 2; i < N; i++) begin
            @(negedge clk);
            expect_eq("R7 done not early", 64'(done), 64'd0);
        end
        @(negedge clk);
        expect_eq("R7 done on time", 64'(done), 64'd1);
        expect_eq("R7 product of first operands", 64'(product), 64'h06);

        // R8 product held over several idle cycles with changing inputs
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            a = N'(i + 5); b = N'(i + 9);
            expect_eq("R8 product held idle", 64'(product), 64'h06);
            expect_eq("R8 done low idle", 64'(done), 64'd0);
        end

        // R1 reset in the middle of a run
        @(negedge clk);
        start = 1'b1; a = 4'd5; b = 4'd5;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        expect_eq("R1 busy after mid-run reset", 64'(busy), 64'd0);
        expect_eq("R1 product after mid-run reset", 64'(product), 64'd0);
        for (int i = 0; i < N + 1; i++) begin
            @(negedge clk);
            expect_eq("R1 no done after mid-run reset", 64'(done), 64'd0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule